// File: doc/BRIEF.md
# Stalled Rotor Detector and Protection Latch

This block watches a three-phase brushless motor for a rotor that has stopped turning while the driver is still commanded to run. An external timing source supplies one pulse per period of its timing ramp. A counter advances on each of these pulses. It returns to zero whenever the parity of the three Hall position signals changes, which happens on every single-sensor commutation step. If enough timing pulses arrive with no Hall activity, the counter runs past its last value. The block then raises a stall-detect flag, and that flag in turn sets a protection latch.

The protection latch is meant to hold the bridge driver in suspend. It stays set after the rotor starts moving again. Only a power-on reset, a change of level on the run/stop command, or a change of level on the direction command can release it. While the run/stop input commands stop, the detector is idle: the counter is held at zero and stall-detect is held low.

All inputs are asynchronous to the block clock. Each one passes through a synchroniser before it is used. The timing pulse is counted on the rising edge of its synchronised copy.

Top module: `stall_guard`

## Requirements
- R1: After power-on reset (rstN low) both stallDetect and stallProtect are 0.
- R2: While runN is 1 (stop command), timing pulses have no effect: the count stays at zero and stallDetect stays 0. After runN returns to 0, a stall needs a full 2^CNT_W fresh pulses.
- R3: With runN at 0 and no Hall activity, stallDetect rises on the 2^CNT_W-th timing pulse (16 with the default CNT_W of 4). It is still 0 after 2^CNT_W-1 pulses.
- R4: A change of exactly one of hallAb, hallBc, hallCa clears the count to zero and drops stallDetect.
- R5: Activity is detected through the exclusive-OR of the three Hall signals. If two Hall signals change in the same clock, the count is not cleared.
- R6: When stallDetect is 1, stallProtect becomes 1 and stays 1 after Hall activity resumes and stallDetect falls.
- R7: Any change of level on runN clears stallProtect.
- R8: Any change of level on dirIn clears stallProtect, clears stallDetect and restarts the count from zero.
- R9: A power-on reset clears a set stallProtect.
- R10: Each timing pulse advances the count exactly once, however many clocks it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, active low |
| tickIn | input | 1 | Timing pulse, one per timing-ramp period (asynchronous) |
| hallAb | input | 1 | Hall position signal between phases A and B |
| hallBc | input | 1 | Hall position signal between phases B and C |
| hallCa | input | 1 | Hall position signal between phases C and A |
| runN | input | 1 | Run/stop command, 0 = run |
| dirIn | input | 1 | Direction command |
| stallDetect | output | 1 | Stall seen: count overflowed with no Hall activity |
| stallProtect | output | 1 | Latched stall protection, forces the driver into suspend |

## Verification
The assertions assume that every input stays at one level long enough for the synchroniser to capture it. They also assume that a timing pulse, a Hall step, a run toggle and a direction toggle never reach the control logic in the same clock, so the priority among them is never exercised. The stimulus keeps within these assumptions. Every input change, including each high and low phase of a timing pulse, is followed by a settle time of several clocks before the next one. Random events are issued strictly one at a time. Hall steps follow a six-state one-bit-per-step sequence, except in the directed case that changes two signals at once.

// File: rtl/stall_pkg.sv
package stall_pkg;

  // bit positions inside the synchronised input vector
  localparam int IDX_AB   = 0;
  localparam int IDX_BC   = 1;
  localparam int IDX_CA   = 2;
  localparam int IDX_RUN  = 3;
  localparam int IDX_DIR  = 4;
  localparam int IDX_TICK = 5;
  localparam int IN_W     = 6;

  // reset image: stop commanded, everything else low
  localparam logic [IN_W-1:0] IN_RESET = 6'b001000;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } stall_cmd_t;

  // datapath -> control status
  typedef struct packed {
    logic tickEdge;
    logic hallEdge;
    logic runEdge;
    logic dirEdge;
    logic runIdle;
    logic cntFull;
  } stall_stat_t;

endpackage

// File: rtl/stall_sync.sv
module stall_sync #(
  parameter int WIDTH = 6,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[0] <= RESET_VAL;
        else       pipe[0] <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/stall_datapath.sv
module stall_datapath
  import stall_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   rawIn,
  input  stall_cmd_t        cmd,
  output stall_stat_t       stat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IN_W-1:0]  syncVec;
  logic [IN_W-1:0]  prevVec;
  logic [CNT_W-1:0] count;
  logic             hallPar;
  logic             hallParPrev;

  stall_sync #(
    .WIDTH(IN_W),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(IN_RESET)
  ) i_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn(rawIn),
    .syncOut(syncVec)
  );

  // registered copy for edge finding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= IN_RESET;
    else       prevVec <= syncVec;
  end

  // Hall activity is seen as a change of the parity of all three sensors
  assign hallPar     = syncVec[IDX_AB] ^ syncVec[IDX_BC] ^ syncVec[IDX_CA];
  assign hallParPrev = prevVec[IDX_AB] ^ prevVec[IDX_BC] ^ prevVec[IDX_CA];

  always_comb begin
    stat.tickEdge = syncVec[IDX_TICK] & ~prevVec[IDX_TICK];
    stat.hallEdge = hallPar ^ hallParPrev;
    stat.runEdge  = syncVec[IDX_RUN] ^ prevVec[IDX_RUN];
    stat.dirEdge  = syncVec[IDX_DIR] ^ prevVec[IDX_DIR];
    stat.runIdle  = syncVec[IDX_RUN];
    stat.cntFull  = (count == CNT_MAX);
  end

  // timing-pulse counter, saturating at its last value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (cmd.cntClear) count <= '0;
    else if (cmd.cntInc)   count <= count + 1'b1;
  end

  // R2: stop command leaves the counter at zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    stat.runIdle |=> (count == '0));

  // R3: a full counter never wraps without a clear
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stat.cntFull && !cmd.cntClear) |=> stat.cntFull);

  // R10: one step per clock at most
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.cntClear && !stat.cntFull) |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/stall_control.sv
module stall_control
  import stall_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stall_stat_t stat,
  output stall_cmd_t  cmd,
  output logic        stallDetect,
  output logic        stallProtect
);

  logic overflowHit;
  logic latchRelease;

  always_comb begin
    cmd.cntClear = stat.runIdle | stat.hallEdge | stat.dirEdge;
    cmd.cntInc   = stat.tickEdge & ~stat.cntFull & ~cmd.cntClear;
    overflowHit  = stat.tickEdge & stat.cntFull & ~cmd.cntClear;
    latchRelease = stat.runEdge | stat.dirEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             stallDetect <= 1'b0;
    else if (cmd.cntClear) stallDetect <= 1'b0;
    else if (overflowHit)  stallDetect <= 1'b1;
  end

  // release wins over set so a toggle during a stall starts a fresh attempt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             stallProtect <= 1'b0;
    else if (latchRelease) stallProtect <= 1'b0;
    else if (stallDetect)  stallProtect <= 1'b1;
  end

  // R2: no detect while stopped
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stat.runIdle |=> !stallDetect);

  // R3: detect only rises out of a full counter
  a_r3_rise_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallDetect) |-> $past(stat.cntFull));

  // R4: Hall activity drops detect
  a_r4_edge_clears: assert property (@(posedge clk) disable iff (!rstN)
    stat.hallEdge |=> !stallDetect);

  // R6: detect sets the latch unless a toggle releases it
  a_r6_latch_sets: assert property (@(posedge clk) disable iff (!rstN)
    (stallDetect && !latchRelease) |=> stallProtect);

  // R6: the latch never falls without a toggle
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stallProtect && !latchRelease) |=> stallProtect);

  // R7 and R8: run or direction toggle releases the latch
  a_r7_toggle_clears: assert property (@(posedge clk) disable iff (!rstN)
    latchRelease |=> !stallProtect);

endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  input  logic hallAb,
  input  logic hallBc,
  input  logic hallCa,
  input  logic runN,
  input  logic dirIn,
  output logic stallDetect,
  output logic stallProtect
);

  logic [IN_W-1:0] rawIn;
  stall_cmd_t      cmd;
  stall_stat_t     stat;

  always_comb begin
    rawIn           = '0;
    rawIn[IDX_AB]   = hallAb;
    rawIn[IDX_BC]   = hallBc;
    rawIn[IDX_CA]   = hallCa;
    rawIn[IDX_RUN]  = runN;
    rawIn[IDX_DIR]  = dirIn;
    rawIn[IDX_TICK] = tickIn;
  end

  stall_datapath #(
    .CNT_W(CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk),
    .rstN(rstN),
    .rawIn(rawIn),
    .cmd(cmd),
    .stat(stat)
  );

  stall_control i_control (
    .clk(clk),
    .rstN(rstN),
    .stat(stat),
    .cmd(cmd),
    .stallDetect(stallDetect),
    .stallProtect(stallProtect)
  );

endmodule

// File: tb/test_stall_guard.sv
module test_stall_guard;

  localparam int CNT_W  = 4;
  localparam int FULL   = 1 << CNT_W;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic hallAb = 1'b0, hallBc = 1'b0, hallCa = 1'b0;
  logic runN = 1'b1;
  logic dirIn = 1'b0;
  logic stallDetect, stallProtect;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // model state
  int ticks = 0;
  bit expDet = 1'b0;
  bit expProt = 1'b0;
  int hallIdx = 0;

  always #10 clk = ~clk;

  stall_guard #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_stall_guard (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .hallAb(hallAb), .hallBc(hallBc), .hallCa(hallCa),
    .runN(runN), .dirIn(dirIn),
    .stallDetect(stallDetect), .stallProtect(stallProtect)
  );

  function automatic logic [2:0] hallCode(int idx);
    case (idx)
      0: return 3'b001;
      1: return 3'b011;
      2: return 3'b010;
      3: return 3'b110;
      4: return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  function automatic bit detFrom(int t, bit stopped);
    return !stopped && (t >= FULL);
  endfunction

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic updateModel();
    expDet = detFrom(ticks, runN);
    if (expDet) expProt = 1'b1;
  endtask

  task automatic checkOut(string tag);
    @(negedge clk);
    nChecks++;
    if (stallDetect !== expDet || stallProtect !== expProt) begin
      nFail++;
      $display("FAIL %s: detect=%0b protect=%0b expected detect=%0b protect=%0b",
               tag, stallDetect, stallProtect, expDet, expProt);
    end
  endtask

  task automatic tickPulse(int highCycles);
    tickIn = 1'b1;
    settle(highCycles);
    tickIn = 1'b0;
    settle(SETTLE);
    if (!runN && ticks < FULL) ticks++;
    updateModel();
  endtask

  task automatic ticksN(int n);
    for (int i = 0; i < n; i++) tickPulse(3);
  endtask

  task automatic hallStep();
    hallIdx = (hallIdx + 1) % 6;
    {hallCa, hallBc, hallAb} = hallCode(hallIdx);
    settle(SETTLE);
    ticks = 0;
    updateModel();
  endtask

  task automatic toggleRun();
    runN = ~runN;
    settle(SETTLE);
    ticks = 0;
    expProt = 1'b0;
    updateModel();
  endtask

  task automatic toggleDir();
    dirIn = ~dirIn;
    settle(SETTLE);
    ticks = 0;
    expProt = 1'b0;
    updateModel();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    settle(3);
    rstN = 1'b1;
    settle(2);
    ticks = 0;
    expDet = 1'b0;
    expProt = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: expired, expected completion");
    finishRun();
  end

  initial begin
    int sink;
    sink = $urandom(32'd20240611);
    {hallCa, hallBc, hallAb} = hallCode(0);
    settle(5);
    rstN = 1'b1;
    settle(3);
    checkOut("R1 reset state");

    // R2: ticks while stopped
    ticksN(FULL + 4);
    checkOut("R2 stopped ignores pulses");
    toggleRun();                 // start running
    ticksN(FULL - 1);
    checkOut("R2 R3 no detect one pulse short");
    ticksN(1);
    checkOut("R3 detect on final pulse, R6 latch set");

    // R4 / R6
    hallStep();
    checkOut("R4 R6 hall step clears detect, latch holds");

    // R7
    toggleRun();
    checkOut("R7 run toggle clears latch");
    toggleRun();
    checkOut("R7 back to run");

    // R8
    ticksN(FULL);
    checkOut("R8 stall again");
    toggleDir();
    checkOut("R8 dir toggle clears latch and detect");
    ticksN(FULL - 1);
    checkOut("R8 count restarted");
    hallStep();

    // R5: two signals change together, no clear
    ticksN(10);
    hallCa = ~hallCa;
    hallBc = ~hallBc;
    settle(SETTLE);
    updateModel();
    checkOut("R5 double change no clear");
    ticksN(FULL - 10);
    checkOut("R5 detect after double change");
    hallStep();
    checkOut("R5 single step clears");

    // R10: long pulses count once
    for (int i = 0; i < FULL - 1; i++) tickPulse((i % 2) ? 20 : 3);
    checkOut("R10 long pulses one count each");
    tickPulse(25);
    checkOut("R10 final long pulse detects");

    // R9
    doReset();
    runN = 1'b1;
    settle(SETTLE);
    updateModel();
    checkOut("R9 reset clears latch");

    // random mix
    toggleRun();
    for (int e = 0; e < 400; e++) begin
      int pick;
      pick = $urandom_range(99);
      if (pick < 70)      tickPulse($urandom_range(8, 1));
      else if (pick < 85) hallStep();
      else if (pick < 93) toggleRun();
      else                toggleDir();
      if (runN) begin
        checkOut("R2 random stopped");
      end else if (expProt) begin
        checkOut("R6 random latch");
      end else begin
        checkOut("R3 R4 random run");
      end
    end

    finishRun();
  end

endmodule